// File: doc/BRIEF.md
# Speech ROM Serial Bit Sequencer

This block sits between a serial speech synthesizer and an 8-bit-wide speech ROM. The synthesizer pulls its coefficient stream one bit at a time. On each single-cycle request strobe the block picks one bit lane out of the byte at the current ROM address, returns that bit on the next cycle, and advances a 12-bit address counter. A 13th address bit, the bank offset, selects the upper or lower half of the ROM.

A processor write to a 5-bit control port does three things. It chooses the bit lane through a bit-reversed mapping, it may change the bank offset, and it starts a control sequence. The sequence walks a fixed 16-entry internal table, one entry every `STEP_DIV` clock cycles. Each entry sets the synthesizer's speak/reset command line and its data-clock line, and it may zero the address counter. The entry that carries the stop flag ends the run. A write that arrives while a run is in progress does not execute an entry at once. It rewinds the table pointer to entry 0 and lets the run carry on from there.

Top module: `speech_bit_seq`

## Requirements
- R1: The bit lane is the bit reversal of `ctl_data[2:0]`: 0→0, 1→4, 2→2, 3→6, 4→1, 5→5, 6→3, 7→7.
- R2: On a write, `ctl_data[4:3]`=1 sets the bank bit (`rom_addr[12]`) to 1 and `ctl_data[4:3]`=3 sets it to 0. Values 0 and 2 leave it unchanged.
- R3: A write while idle (`busy`=0) executes table entry 0 on that clock edge, which gives `speak`=0 and `dclk`=1, and `busy` becomes 1.
- R4: A write while `busy`=1 executes no entry and leaves `speak` and `dclk` unchanged. Entry 0 then executes `STEP_DIV` cycles after that write, and the following entries come at the normal rate.
- R5: Entry k of a run executes k·`STEP_DIV` cycles after the starting edge. Entry 15 carries the stop flag, after which `busy` is 0 and `speak`=1, `dclk`=1.
- R6: The table sets `dclk` low at entries 2, 5, 8 and 13 and high at all others. It sets `speak` to 1 at entries 12 to 15 and to 0 at all others. Entry 10 zeroes the address counter.
- R7: A request strobe `bit_req` makes `bit_out` equal `rom_data[lane]` read at the presented `rom_addr` on the next cycle, and the address counter advances by one.
- R8: The address counter wraps from 4095 to 0, and the bank bit is not affected by the wrap.
- R9: After reset `rom_addr`=0, lane 0, `busy`=0, `speak`=0, `dclk`=1 and `bit_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control port write strobe |
| ctl_data | input | 5 | Control byte: [2:0] lane code, [4:3] bank code |
| bit_req | input | 1 | Single-cycle request for the next serial bit |
| rom_data | input | 8 | Byte read from the ROM at `rom_addr` |
| rom_addr | output | 13 | ROM address: bank bit above the 12-bit counter |
| bit_out | output | 1 | Requested data bit, valid the cycle after `bit_req` |
| speak | output | 1 | Synthesizer command: 1 speak, 0 reset |
| dclk | output | 1 | Synthesizer data-clock line |
| busy | output | 1 | A control sequence is running |

## Verification
The address-increment property assumes two things about the inputs: the synthesizer asks for bits only while no sequence is running, and `rom_data` follows `rom_addr` combinationally in the same cycle. The bench keeps to both. It issues every request after `busy` has fallen, and it models the ROM as a pure function of the address. The bench never raises a write and a request in the same cycle. It also changes inputs only on the falling clock edge, so each write or request is seen by exactly one rising edge.

// File: rtl/speech_bit_seq.sv
module speech_bit_seq #(
  parameter int STEP_DIV = 156,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [4:0]        ctl_data,
  input  logic              bit_req,
  input  logic [7:0]        rom_data,
  output logic [ADDR_W:0]   rom_addr,
  output logic              bit_out,
  output logic              speak,
  output logic              dclk,
  output logic              busy
);
  localparam int DIV_W = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_DIV - 1);

  // entry fields: {stop, clear_addr, speak, dclk_low}
  function automatic logic [3:0] seq_entry(input logic [3:0] i);
    case (i)
      4'd2, 4'd5, 4'd8: seq_entry = 4'b0001;
      4'd10:            seq_entry = 4'b0100;
      4'd12, 4'd14:     seq_entry = 4'b0010;
      4'd13:            seq_entry = 4'b0011;
      4'd15:            seq_entry = 4'b1010;
      default:          seq_entry = 4'b0000;
    endcase
  endfunction

  logic [4:0]        step_cnt;
  logic [DIV_W-1:0]  div;
  logic              running;
  logic [ADDR_W-1:0] addr;
  logic              bank;
  logic [2:0]        lane;

  wire       at_end  = step_cnt[4];
  wire       tick    = running && (div == DIV_LAST);
  wire       kick    = ctl_we && at_end;
  wire       do_step = kick || (tick && !ctl_we);
  wire [3:0] idx     = kick ? 4'd0 : step_cnt[3:0];
  wire [3:0] ent     = seq_entry(idx);

  assign rom_addr = {bank, addr};
  assign busy     = running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt <= 5'd16;
      div      <= '0;
      running  <= 1'b0;
      speak    <= 1'b0;
      dclk     <= 1'b1;
    end else if (ctl_we && !at_end) begin
      step_cnt <= 5'd0;
      div      <= '0;
    end else if (do_step) begin
      step_cnt <= {1'b0, idx} + 5'd1;
      div      <= '0;
      running  <= !ent[3];
      speak    <= ent[1];
      dclk     <= !ent[0];
    end else if (running) begin
      div <= div + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane <= 3'd0;
      bank <= 1'b0;
    end else if (ctl_we) begin
      lane <= {ctl_data[0], ctl_data[1], ctl_data[2]};
      if (ctl_data[4:3] == 2'd1)      bank <= 1'b1;
      else if (ctl_data[4:3] == 2'd3) bank <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      bit_out <= 1'b0;
    end else begin
      if (do_step && ent[2])  addr <= '0;
      else if (bit_req)       addr <= addr + 1'b1;
      if (bit_req) bit_out <= rom_data[lane];
    end
  end
endmodule

// File: rtl/speech_bit_seq_chk.sv
module speech_bit_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ctl_we,
  input logic [4:0]      ctl_data,
  input logic            bit_req,
  input logic [ADDR_W:0] rom_addr,
  input logic            speak,
  input logic            dclk,
  input logic            busy
);
  AST_BANK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_data[4:3] == 2'd1 |=> rom_addr[ADDR_W]); // R2
  AST_BANK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_data[4:3] == 2'd3 |=> !rom_addr[ADDR_W]); // R2
  AST_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !ctl_data[3] |=> $stable(rom_addr[ADDR_W])); // R2
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !busy |=> busy && !speak && dclk); // R3
  AST_RESTART_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && busy |=> busy && $stable(speak) && $stable(dclk)); // R4
  AST_STOP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> speak && dclk); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !ctl_we |=> $stable(speak) && $stable(dclk) && !busy); // R5
  AST_ADDR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req && !busy |=> rom_addr[ADDR_W-1:0] == $past(rom_addr[ADDR_W-1:0]) + 1'b1); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_req && !busy && !ctl_we |=> $stable(rom_addr)); // R7
endmodule

bind speech_bit_seq speech_bit_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(ctl_data),
  .bit_req(bit_req), .rom_addr(rom_addr), .speak(speak), .dclk(dclk),
  .busy(busy)
);

// File: tb/sim_speech_bit_seq.sv
module sim_speech_bit_seq;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [4:0]  ctl_data = '0;
  logic        bit_req = 1'b0;
  logic [7:0]  rom_data;
  logic [12:0] rom_addr;
  logic        bit_out, speak, dclk, busy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic exp_bank = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] romf(input logic [12:0] a);
    romf = 8'(a * 13'd37) ^ 8'(a >> 5) ^ {3'b0, a[12], 4'b0};
  endfunction
  assign rom_data = romf(rom_addr);

  speech_bit_seq #(.STEP_DIV(D)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .bit_req(bit_req), .rom_data(rom_data), .rom_addr(rom_addr),
    .bit_out(bit_out), .speak(speak), .dclk(dclk), .busy(busy)
  );

  // {ctl, expected bank, expected lane}
  localparam logic [8:0] VEC [6] = '{
    {5'h08, 1'b1, 3'd0}, {5'h19, 1'b0, 3'd4}, {5'h03, 1'b0, 3'd6},
    {5'h0E, 1'b1, 3'd3}, {5'h12, 1'b1, 3'd2}, {5'h1D, 1'b0, 3'd5}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(input logic [4:0] v);
    ctl_data = v; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic read_bit(input logic [2:0] lane);
    logic [12:0] a;
    a = rom_addr;
    bit_req = 1'b1;
    @(negedge clk);
    bit_req = 1'b0;
    chk("R1/R7 bit_out", 16'(bit_out), 16'(romf(a)[lane]));
    chk("R7 addr step", 16'(rom_addr), 16'({a[12], a[11:0] + 12'd1}));
  endtask

  function automatic logic exp_dclk(input int k);
    exp_dclk = !(k == 2 || k == 5 || k == 8 || k == 13);
  endfunction

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk("R9 rom_addr", 16'(rom_addr), 16'h0);
    chk("R9 busy", 16'(busy), 16'h0);
    chk("R9 speak", 16'(speak), 16'h0);
    chk("R9 dclk", 16'(dclk), 16'h1);
    chk("R9 bit_out", 16'(bit_out), 16'h0);
    read_bit(3'd0);

    foreach (VEC[i]) begin
      write_ctl(VEC[i][8:4]);
      exp_bank = VEC[i][3];
      chk("R3 busy", 16'(busy), 16'h1);
      chk("R3 speak", 16'(speak), 16'h0);
      chk("R3 dclk", 16'(dclk), 16'h1);
      for (int k = 1; k < 16; k++) begin
        wait_n(D - 1);
        chk("R5 no early step", 16'(dclk), 16'(exp_dclk(k - 1)));
        wait_n(1);
        chk("R6 dclk", 16'(dclk), 16'(exp_dclk(k)));
        chk("R6 speak", 16'(speak), 16'(k >= 12));
      end
      chk("R5 busy end", 16'(busy), 16'h0);
      chk("R2/R6 addr after run", 16'(rom_addr), 16'({exp_bank, 12'h000}));
      for (int r = 0; r < 6; r++) read_bit(VEC[i][2:0]);
    end

    // R4: restart while running
    write_ctl(5'h08);
    wait_n(2 * D);
    chk("R4 entry2 reached", 16'(dclk), 16'h0);
    wait_n(1);
    write_ctl(5'h08);
    chk("R4 no step on restart", 16'(dclk), 16'h0);
    chk("R4 busy", 16'(busy), 16'h1);
    wait_n(D - 1);
    chk("R4 still held", 16'(dclk), 16'h0);
    wait_n(1);
    chk("R4 entry0 after restart", 16'(dclk), 16'h1);
    wait_n(2 * D);
    chk("R4 entry2 after restart", 16'(dclk), 16'h0);
    wait_n(13 * D - 1);
    chk("R4 busy before last", 16'(busy), 16'h1);
    wait_n(1);
    chk("R5 busy after last", 16'(busy), 16'h0);
    chk("R5 speak after last", 16'(speak), 16'h1);

    // R8: wrap
    chk("R8 start", 16'(rom_addr), 16'h1000);
    bit_req = 1'b1;
    wait_n(4095);
    bit_req = 1'b0;
    chk("R8 top", 16'(rom_addr), 16'h1FFF);
    read_bit(3'd0);
    chk("R8 wrapped", 16'(rom_addr), 16'h1000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule